// File: doc/BRIEF.md
# Correlating Two-Bit Branch Direction Predictor

This block gives a pipelined fetch stage a taken/not-taken guess for a branch in the same cycle it sees the fetch address. The guess comes from a table of two-bit saturating counters. The table row is chosen by the low instruction-address bits of the branch, taken from just above the alignment bits, together with the actual outcome of the most recent branch to resolve. The same static branch can therefore learn two different behaviours, depending on what the branch before it did.

Later in the pipeline, a resolve port reports each branch's instruction-address bits, its real direction and the guess that fetch acted on. The block trains the selected counter and records the outcome as the new previous-branch bit. If the guess was wrong, it raises a one-cycle flush in the following cycle. A static mode input makes the lookup ignore the table. In that mode it follows a valid hint bit, or, when there is no hint, predicts backward branches taken and forward branches not taken. The table keeps training in both modes.

Top module: `bpred_correlating`

## Requirements
- R1: After synchronous reset every counter holds 01 (weakly not-taken) and the previous-outcome bit is 0, so every table lookup predicts not-taken and flush is low.
- R2: The table row is {previous-outcome bit, instruction-address index bits}, with the previous-outcome bit as the most significant index bit. Lookup and resolve use the same mapping.
- R3: A valid resolve sets the previous-outcome bit to its actual outcome. Lookups and the next update then use the half of the table that this bit selects.
- R4: Counters use 00 for strongly not-taken, 01 for weakly not-taken, 10 for weakly taken and 11 for strongly taken. The table predicts taken when bit 1 is set. A taken resolve adds one and stops at 11. A not-taken resolve subtracts one and stops at 00.
- R5: A counter at 11 that gets one not-taken resolve still predicts taken. A counter at 00 that gets one taken resolve still predicts not-taken.
- R6: In static mode with no valid hint, the prediction is taken exactly when the offset-negative input is 1.
- R7: In static mode with the hint valid, the prediction equals the hint value, whatever the offset sign.
- R8: The flush output is high for exactly the one cycle after a valid resolve whose actual outcome differs from its supplied prediction. It is low in every other cycle.
- R9: When the resolve valid input is low, neither the counters nor the previous-outcome bit change.
- R10: When a lookup and a resolve select the same row in one cycle, the lookup returns the counter value from before the update. The update takes effect at that clock edge.
- R11: Resolves train the table and the previous-outcome bit in static mode as well. Static-mode predictions never depend on table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| static_mode | input | 1 | 1 selects static prediction for lookups |
| lk_addr_idx | input | IDX_W | Instruction-address index bits of the fetched branch |
| lk_off_neg | input | 1 | Branch offset is negative (backward branch) |
| lk_hint_vld | input | 1 | Hint bit present for this branch |
| lk_hint_taken | input | 1 | Hint value, 1 = taken |
| lk_taken | output | 1 | Prediction for the lookup, combinational |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_addr_idx | input | IDX_W | Instruction-address index bits of the resolving branch |
| rs_taken | input | 1 | Actual outcome of the resolving branch |
| rs_pred | input | 1 | Prediction that fetch used for that branch |
| flush | output | 1 | One-cycle request to discard wrongly fetched instructions |

## Verification
The hardest case to reach is a lookup that hits a row at the exact edge where that row is being trained. To get there, the lookup must use the same address bits as the resolve, and the previous-outcome bit must already point at the half of the table being written. The stimulus first trains the rows into known states. It then drives identical lookup and resolve addresses on consecutive cycles, with outcomes chosen so that the previous-outcome bit does not move. It also walks a strongly taken row through a single opposite outcome. In that walk an unrelated branch is resolved in between, which puts the correlation bit back on the original half. A behavioural model of the counters and of the previous-outcome bit is compared with the lookup and flush outputs on every cycle.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WEAK_NT;

    typedef struct packed {
        logic off_neg;
        logic hint_vld;
        logic hint_taken;
    } static_info_t;

    typedef struct packed {
        logic valid;
        logic taken;
        logic pred;
    } resolve_t;

    function automatic ctr_e ctr_step(ctr_e cur, logic taken);
        ctr_e nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = ctr_e'(cur + 2'd1);
        end else begin
            if (cur != CTR_STRONG_NT) nxt = ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(ctr_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/bpred_index.sv
module bpred_index #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] addr_idx,
    input  logic             prev_taken,
    output logic [IDX_W:0]   row
);
    // correlation bit is the most significant row bit
    assign row = {prev_taken, addr_idx};
endmodule

// File: rtl/bpred_static.sv
module bpred_static
    import bpred_pkg::*;
(
    input  static_info_t info,
    output logic         taken
);
    always_comb begin
        if (info.hint_vld) taken = info.hint_taken;
        else               taken = info.off_neg;
    end

    always_comb begin
        if (info.hint_vld)
            AST_HINT_WINS: assert (taken == info.hint_taken); // R7
        else
            AST_BACKWARD_TAKEN: assert (taken == info.off_neg); // R6
    end
endmodule

// File: rtl/bpred_ctr_table.sv
module bpred_ctr_table
    import bpred_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_row,
    output ctr_e          rd_ctr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_row,
    input  logic          wr_taken
);
    localparam int DEPTH = 1 << AW;

    ctr_e mem [DEPTH];
    ctr_e old_ctr;

    // read is combinational: a same-cycle write is seen only after the edge
    assign rd_ctr  = mem[rd_row];
    assign old_ctr = mem[wr_row];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_RESET;
        end else if (wr_en) begin
            mem[wr_row] <= ctr_step(old_ctr, wr_taken);
        end
    end

    AST_INC_NO_DROP: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken |=> (mem[$past(wr_row)] >= $past(old_ctr))); // R4
    AST_DEC_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_taken |=> (mem[$past(wr_row)] <= $past(old_ctr))); // R4
    AST_STRONG_T_HOLDS: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_taken && old_ctr == CTR_STRONG_T
        |=> ctr_says_taken(mem[$past(wr_row)])); // R5
    AST_STRONG_NT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_taken && old_ctr == CTR_STRONG_NT
        |=> !ctr_says_taken(mem[$past(wr_row)])); // R5
endmodule

// File: rtl/bpred_correlating.sv
module bpred_correlating
    import bpred_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             static_mode,
    input  logic [IDX_W-1:0] lk_addr_idx,
    input  logic             lk_off_neg,
    input  logic             lk_hint_vld,
    input  logic             lk_hint_taken,
    output logic             lk_taken,
    input  logic             rs_valid,
    input  logic [IDX_W-1:0] rs_addr_idx,
    input  logic             rs_taken,
    input  logic             rs_pred,
    output logic             flush
);
    localparam int ROW_W  = IDX_W + 1;
    localparam int NPORTS = 2;   // 0 = lookup, 1 = resolve

    logic         prev_q;
    logic         flush_q;
    static_info_t st_info;
    resolve_t     rsv;
    logic         stat_taken;
    ctr_e         lk_ctr;

    logic [IDX_W-1:0] port_addr [NPORTS];
    logic [ROW_W-1:0] port_row  [NPORTS];

    assign port_addr[0] = lk_addr_idx;
    assign port_addr[1] = rs_addr_idx;

    for (genvar p = 0; p < NPORTS; p++) begin : g_idx
        bpred_index #(.IDX_W(IDX_W)) idx_i (
            .addr_idx   (port_addr[p]),
            .prev_taken (prev_q),
            .row        (port_row[p])
        );
    end

    assign st_info = '{off_neg: lk_off_neg, hint_vld: lk_hint_vld, hint_taken: lk_hint_taken};
    assign rsv     = '{valid: rs_valid, taken: rs_taken, pred: rs_pred};

    bpred_static static_i (
        .info  (st_info),
        .taken (stat_taken)
    );

    bpred_ctr_table #(.AW(ROW_W)) table_i (
        .clk      (clk),
        .rst      (rst),
        .rd_row   (port_row[0]),
        .rd_ctr   (lk_ctr),
        .wr_en    (rsv.valid),
        .wr_row   (port_row[1]),
        .wr_taken (rsv.taken)
    );

    assign lk_taken = static_mode ? stat_taken : ctr_says_taken(lk_ctr);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            if (rsv.valid) prev_q <= rsv.taken;
            flush_q <= rsv.valid && (rsv.taken != rsv.pred);
        end
    end

    assign flush = flush_q;

    AST_FLUSH_ON_MISS: assert property (@(posedge clk) disable iff (rst)
        rs_valid && (rs_taken != rs_pred) |=> flush); // R8
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(rs_valid && (rs_taken != rs_pred)) |=> !flush); // R8
    AST_PREV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rs_valid |=> $stable(prev_q)); // R9
    AST_PREV_TRACK: assert property (@(posedge clk) disable iff (rst)
        rs_valid |=> prev_q == $past(rs_taken)); // R3
endmodule

// File: tb/bpred_correlating_tb.sv
module bpred_correlating_tb_top;
    localparam int IDX_W = 6;
    localparam int DEPTH = 1 << (IDX_W + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic static_mode = 1'b0;
    logic [IDX_W-1:0] lk_addr_idx = '0;
    logic lk_off_neg = 1'b0, lk_hint_vld = 1'b0, lk_hint_taken = 1'b0;
    logic lk_taken;
    logic rs_valid = 1'b0;
    logic [IDX_W-1:0] rs_addr_idx = '0;
    logic rs_taken = 1'b0, rs_pred = 1'b0;
    logic flush;

    always #4 clk = ~clk;

    bpred_correlating #(.IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst(rst), .static_mode(static_mode),
        .lk_addr_idx(lk_addr_idx), .lk_off_neg(lk_off_neg),
        .lk_hint_vld(lk_hint_vld), .lk_hint_taken(lk_hint_taken),
        .lk_taken(lk_taken), .rs_valid(rs_valid), .rs_addr_idx(rs_addr_idx),
        .rs_taken(rs_taken), .rs_pred(rs_pred), .flush(flush)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int mdl_ctr [DEPTH];
    bit mdl_prev;
    bit mdl_flush;

    function automatic int mdl_row(logic [IDX_W-1:0] a);
        return (mdl_prev ? (1 << IDX_W) : 0) + int'(a);
    endfunction

    function automatic bit mdl_lookup();
        if (static_mode) return lk_hint_vld ? lk_hint_taken : lk_off_neg;
        return mdl_ctr[mdl_row(lk_addr_idx)] >= 2;
    endfunction

    task automatic check(string tag, string what, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic mdl_reset();
        for (int i = 0; i < DEPTH; i++) mdl_ctr[i] = 1;
        mdl_prev = 0;
        mdl_flush = 0;
    endtask

    // inputs already set just after a falling edge
    task automatic tick(string tag);
        int r;
        #1;
        check(tag, "lk_taken", lk_taken, mdl_lookup());
        @(posedge clk);
        if (rs_valid) begin
            r = mdl_row(rs_addr_idx);
            if (rs_taken && mdl_ctr[r] < 3) mdl_ctr[r]++;
            if (!rs_taken && mdl_ctr[r] > 0) mdl_ctr[r]--;
            mdl_prev = rs_taken;
        end
        mdl_flush = rs_valid && (rs_taken != rs_pred);
        @(negedge clk);
        check(tag, "flush", flush, mdl_flush);
    endtask

    task automatic lk(logic [IDX_W-1:0] a, bit neg, bit hv, bit ht);
        lk_addr_idx = a; lk_off_neg = neg; lk_hint_vld = hv; lk_hint_taken = ht;
    endtask

    task automatic rs(bit v, logic [IDX_W-1:0] a, bit t, bit p);
        rs_valid = v; rs_addr_idx = a; rs_taken = t; rs_pred = p;
    endtask

    task automatic rnd_cycle(string tag, bit allow_rs);
        lk(IDX_W'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        rs(allow_rs & 1'($urandom), IDX_W'($urandom), 1'($urandom), 1'($urandom));
        tick(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        mdl_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            lk(IDX_W'(i * 9), 0, 0, 0); rs(0, 0, 0, 0);
            tick("R1");
        end

        // R4: saturate up then down on one branch
        for (int i = 0; i < 5; i++) begin
            lk(6'd5, 0, 0, 0); rs(1, 6'd5, 1, 1);
            tick("R4");
        end
        for (int i = 0; i < 6; i++) begin
            lk(6'd5, 0, 0, 0); rs(1, 6'd5, 0, 0);
            tick("R4");
        end

        // R5: strongly taken row survives one not-taken
        for (int i = 0; i < 4; i++) begin lk(6'd9, 0, 0, 0); rs(1, 6'd9, 1, 1); tick("R5"); end
        lk(6'd9, 0, 0, 0); rs(1, 6'd9, 0, 1); tick("R5");
        lk(6'd9, 0, 0, 0); rs(1, 6'd30, 1, 0); tick("R5");
        lk(6'd9, 0, 0, 0); rs(0, 0, 0, 0); tick("R5");

        // R3 / R2: same branch, alternating previous outcome
        for (int i = 0; i < 24; i++) begin
            lk(6'd12, 0, 0, 0);
            rs(1, (i % 2) ? 6'd12 : 6'd40, (i % 4) < 2, 0);
            tick("R3");
        end
        for (int i = 0; i < 40; i++) rnd_cycle("R2", 1);

        // R10: lookup and update on the same row in the same cycle
        for (int i = 0; i < 12; i++) begin
            lk(6'd20, 0, 0, 0); rs(1, 6'd20, i < 6, 0);
            tick("R10");
        end

        // R9: resolve fields without valid
        for (int i = 0; i < 20; i++) rnd_cycle("R9", 0);
        for (int i = 0; i < 4; i++) begin lk(IDX_W'(i * 13), 0, 0, 0); rs(0, 0, 0, 0); tick("R9"); end

        // R8: mispredicts and correct predictions interleaved
        for (int i = 0; i < 16; i++) begin
            lk(6'd3, 0, 0, 0); rs(1, 6'd3, i[0], i[1]);
            tick("R8");
            lk(6'd3, 0, 0, 0); rs(i[2], 6'd3, 1, 0);
            tick("R8");
        end

        // R6 / R7: static mode
        static_mode = 1'b1;
        for (int i = 0; i < 8; i++) begin
            lk(IDX_W'(i), i[0], 0, 1); rs(0, 0, 0, 0); tick("R6");
        end
        for (int i = 0; i < 8; i++) begin
            lk(IDX_W'(i), i[0], 1, i[1]); rs(0, 0, 0, 0); tick("R7");
        end

        // R11: static mode still trains
        for (int i = 0; i < 20; i++) begin
            lk(6'd44, 1, 0, 0); rs(1, 6'd44, 1, 0); tick("R11");
        end
        for (int i = 0; i < 20; i++) rnd_cycle("R11", 1);
        static_mode = 1'b0;
        for (int i = 0; i < 4; i++) begin lk(6'd44, 0, 0, 0); rs(0, 0, 0, 0); tick("R11"); end

        for (int i = 0; i < 300; i++) begin
            static_mode = ($urandom % 4) == 0;
            rnd_cycle("R4", 1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule